// File: doc/BRIEF.md
# Double-Buffered Converter Register Bank with Rolling Readback

This block keeps the register state of a small group of converter channels. Each channel has a staging (input) pair made of a code and a span, and a live (active) pair that drives the converter. A serial front end, which is outside this block, decodes each frame into a command, an address and a data word. It raises a header strobe once the command and address are known. It raises a frame strobe when chip select returns high. Writes, updates and readback-pointer moves take effect on the frame strobe.

Readback is rolling. A read command loads the chosen buffer into the readback register at the header strobe, so the value goes out in the same frame. Any other command sends back the buffer named by the command of the previous frame. Each command therefore aims the pointer for the next frame, which lets a host verify every write one frame later at no extra cost. An active-low asynchronous update pin acts like the serial update-all command, but only while chip select is high. A manual-span input replaces the stored spans with the levels of the span pins, both on the live outputs and in readback.

Top module: `dbuf_regbank`

## Requirements
- R1: After reset, every code and span register is zero. The readback pointer names the input code buffer of channel 0, so the first non-read frame returns 0.
- R2: On the frame strobe, command 0000 writes the data word into the input code register, and command 0001 writes data bits [2:0] into the input span register. The target is channel 0 for address 0000, channel 1 for address 0001, and every channel for address 1111. Any other address writes nothing.
- R3: On the frame strobe, command 0010 copies input code and input span into the active registers of the addressed channel(s). Command 0011 first writes the input code and then performs the same copy, so the active code takes the new data.
- R4: Command 0100 copies input to active for every channel, whatever the address.
- R5: Commands 0101, 0110, 0111 and 1000 read input code, input span, active code and active span respectively. At the header strobe they load the readback register from the addressed channel. An address that is not a single channel reads channel 0.
- R6: At the header strobe of any non-read frame, the readback register loads the buffer named by the previous command. Commands 0000, 0001, 0010 and 0011 name, in order, the input code, input span, active code and active code of the addressed channel. Command 0100 names the active code of channel 0. Reads name the buffer they read.
- R7: Command 1111 and the unused codes 1001 to 1110 change no register and leave the pointer as it was.
- R8: A span readback word carries the span in bits [2:0], most significant span bit at bit 2, with all higher bits zero.
- R9: While chip select is high, a low level on the update pin copies input to active for every channel. The pin passes through a two-stage synchronizer first.
- R10: While chip select is low, the update pin has no effect on any active register.
- R11: With manual span mode set, the active span outputs and every span readback show the span pins instead of the stored spans.
- R12: If the synchronized update pin is low on the cycle of a frame strobe, the command is applied first. The update-all copy then moves the resulting input values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, low while a frame is in progress |
| hdr_stb | input | 1 | One-cycle pulse: command and address are valid |
| frame_stb | input | 1 | One-cycle pulse at the end of a frame, chip select high |
| cmd | input | 4 | Decoded command |
| addr | input | 4 | Decoded channel address |
| wdata | input | CODE_W | Decoded data word |
| upd_n | input | 1 | Asynchronous active-low update-all |
| manual_span | input | 1 | Take spans from the span pins |
| span_pins | input | SPAN_W | Span pin levels |
| act_code_o | output | NCH*CODE_W | Active codes, channel 0 in the low bits |
| act_span_o | output | NCH*SPAN_W | Effective active spans, channel 0 in the low bits |
| rb_data_o | output | CODE_W | Readback register for the serial front end |

## Verification
The bench builds the block with its default parameters: two channels, 16-bit codes, 3-bit spans and a two-stage synchronizer. This covers both single-channel addresses and the broadcast address, plus out-of-range addresses that must hit nothing. Because the channel count is small, a random mix of commands revisits each of the eight buffers many times. Every non-read frame then checks the pointer left by the frame before it. Random toggling of manual mode and of the update pin during frames reaches the overlap of an update with a command and the lockout while chip select is low.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

    localparam logic [3:0] OP_WR_CODE  = 4'h0;
    localparam logic [3:0] OP_WR_SPAN  = 4'h1;
    localparam logic [3:0] OP_UPD_ONE  = 4'h2;
    localparam logic [3:0] OP_WR_UPD   = 4'h3;
    localparam logic [3:0] OP_UPD_ALL  = 4'h4;
    localparam logic [3:0] OP_RD_ICODE = 4'h5;
    localparam logic [3:0] OP_RD_ISPAN = 4'h6;
    localparam logic [3:0] OP_RD_ACODE = 4'h7;
    localparam logic [3:0] OP_RD_ASPAN = 4'h8;
    localparam logic [3:0] OP_NOP      = 4'hF;

    localparam logic [3:0] ADDR_ALL    = 4'hF;

    typedef enum logic [1:0] {
        BUF_ICODE = 2'd0,
        BUF_ISPAN = 2'd1,
        BUF_ACODE = 2'd2,
        BUF_ASPAN = 2'd3
    } buf_e;

endpackage

// File: rtl/dbuf_sync.sv
module dbuf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n_i,
    output logic sync_n_o
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES > 1) begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], async_n_i};
        end else begin : g_single
            always_comb sync_d = async_n_i;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign sync_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dbuf_chan.sv
module dbuf_chan #(
    parameter int CODE_W = 16,
    parameter int SPAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_code_i,
    input  logic              wr_span_i,
    input  logic              upd_i,
    input  logic [CODE_W-1:0] wcode_i,
    input  logic [SPAN_W-1:0] wspan_i,
    output logic [CODE_W-1:0] in_code_o,
    output logic [SPAN_W-1:0] in_span_o,
    output logic [CODE_W-1:0] act_code_o,
    output logic [SPAN_W-1:0] act_span_o
);
    typedef struct packed {
        logic [CODE_W-1:0] in_code;
        logic [SPAN_W-1:0] in_span;
        logic [CODE_W-1:0] act_code;
        logic [SPAN_W-1:0] act_span;
    } chan_t;

    chan_t ch_d, ch_q;

    // Staging writes land first; the copy to the live pair sees them.
    always_comb begin
        ch_d = ch_q;
        if (wr_code_i) ch_d.in_code = wcode_i;
        if (wr_span_i) ch_d.in_span = wspan_i;
        if (upd_i) begin
            ch_d.act_code = ch_d.in_code;
            ch_d.act_span = ch_d.in_span;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign in_code_o  = ch_q.in_code;
    assign in_span_o  = ch_q.in_span;
    assign act_code_o = ch_q.act_code;
    assign act_span_o = ch_q.act_span;

    assert_wr_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_code_i |=> in_code_o == $past(wcode_i));

    assert_upd_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !wr_code_i && !wr_span_i) |=>
            (act_code_o == $past(in_code_o)) && (act_span_o == $past(in_span_o)));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_code_i && !wr_span_i && !upd_i) |=>
            $stable(in_code_o) && $stable(act_code_o) && $stable(act_span_o));
endmodule

// File: rtl/dbuf_regbank.sv
module dbuf_regbank
    import dbuf_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int CODE_W      = 16,
    parameter int SPAN_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  hdr_stb,
    input  logic                  frame_stb,
    input  logic [3:0]            cmd,
    input  logic [3:0]            addr,
    input  logic [CODE_W-1:0]     wdata,
    input  logic                  upd_n,
    input  logic                  manual_span,
    input  logic [SPAN_W-1:0]     span_pins,
    output logic [NCH*CODE_W-1:0] act_code_o,
    output logic [NCH*SPAN_W-1:0] act_span_o,
    output logic [CODE_W-1:0]     rb_data_o
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic [CH_W-1:0]   ch;
        buf_e              bsel;
        logic [CODE_W-1:0] rb;
    } rbk_t;

    // ---------------- update pin ----------------
    logic upd_sync_n;
    logic ldac_eff;

    dbuf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_n_i (upd_n),
        .sync_n_o  (upd_sync_n)
    );

    assign ldac_eff = !upd_sync_n && cs_n;

    // ---------------- command decode ----------------
    logic [NCH-1:0] hit, wr_code, wr_span, upd;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            hit[c]     = (addr == 4'(c)) || (addr == ADDR_ALL);
            wr_code[c] = frame_stb && hit[c] && (cmd == OP_WR_CODE || cmd == OP_WR_UPD);
            wr_span[c] = frame_stb && hit[c] && (cmd == OP_WR_SPAN);
            upd[c]     = ldac_eff ||
                         (frame_stb && ((hit[c] && (cmd == OP_UPD_ONE || cmd == OP_WR_UPD)) ||
                                        (cmd == OP_UPD_ALL)));
        end
    end

    // ---------------- channels ----------------
    logic [CODE_W-1:0] in_code_w  [NCH];
    logic [SPAN_W-1:0] in_span_w  [NCH];
    logic [CODE_W-1:0] act_code_w [NCH];
    logic [SPAN_W-1:0] act_span_w [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dbuf_chan #(.CODE_W(CODE_W), .SPAN_W(SPAN_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_code_i  (wr_code[c]),
            .wr_span_i  (wr_span[c]),
            .upd_i      (upd[c]),
            .wcode_i    (wdata),
            .wspan_i    (wdata[SPAN_W-1:0]),
            .in_code_o  (in_code_w[c]),
            .in_span_o  (in_span_w[c]),
            .act_code_o (act_code_w[c]),
            .act_span_o (act_span_w[c])
        );
        assign act_code_o[c*CODE_W +: CODE_W] = act_code_w[c];
        assign act_span_o[c*SPAN_W +: SPAN_W] = manual_span ? span_pins : act_span_w[c];
    end

    // ---------------- readback pointer and register ----------------
    rbk_t            st_d, st_q;
    logic [CH_W-1:0] addr_ch;
    logic            is_rd;
    buf_e            rd_b;
    logic            nm_vld;
    logic [CH_W-1:0] nm_ch;
    buf_e            nm_b;
    logic [CH_W-1:0] view_ch;
    buf_e            view_b;
    logic [CODE_W-1:0] view;

    always_comb begin
        addr_ch = (int'(addr) < NCH) ? addr[CH_W-1:0] : '0;

        is_rd = 1'b1;
        rd_b  = BUF_ICODE;
        case (cmd)
            OP_RD_ICODE: rd_b = BUF_ICODE;
            OP_RD_ISPAN: rd_b = BUF_ISPAN;
            OP_RD_ACODE: rd_b = BUF_ACODE;
            OP_RD_ASPAN: rd_b = BUF_ASPAN;
            default:     is_rd = 1'b0;
        endcase

        nm_vld = 1'b1;
        nm_ch  = addr_ch;
        nm_b   = rd_b;
        case (cmd)
            OP_WR_CODE: nm_b = BUF_ICODE;
            OP_WR_SPAN: nm_b = BUF_ISPAN;
            OP_UPD_ONE,
            OP_WR_UPD:  nm_b = BUF_ACODE;
            OP_UPD_ALL: begin
                nm_b  = BUF_ACODE;
                nm_ch = '0;
            end
            default:    nm_vld = is_rd;
        endcase

        view_ch = is_rd ? addr_ch : st_q.ch;
        view_b  = is_rd ? rd_b    : st_q.bsel;
        view    = '0;
        for (int c = 0; c < NCH; c++) begin
            if (CH_W'(c) == view_ch) begin
                case (view_b)
                    BUF_ICODE: view = in_code_w[c];
                    BUF_ISPAN: view = CODE_W'(manual_span ? span_pins : in_span_w[c]);
                    BUF_ACODE: view = act_code_w[c];
                    default:   view = CODE_W'(manual_span ? span_pins : act_span_w[c]);
                endcase
            end
        end

        st_d = st_q;
        if (hdr_stb) st_d.rb = view;
        if (frame_stb && nm_vld) begin
            st_d.ch   = nm_ch;
            st_d.bsel = nm_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rb_data_o = st_q.rb;

    // ---------------- assertions ----------------
    assert_lockout_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !frame_stb) |=> $stable(act_code_o));

    assert_nop_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && cmd == OP_NOP && upd_sync_n) |=>
            $stable(act_code_o) && $stable(st_q.ch) && $stable(st_q.bsel));

    assert_read_aims_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && cmd == OP_RD_ACODE && addr == 4'h0) |=>
            (st_q.bsel == BUF_ACODE) && (st_q.ch == '0));

    assert_span_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_stb && (cmd == OP_RD_ISPAN || cmd == OP_RD_ASPAN)) |=>
            (rb_data_o >> SPAN_W) == '0);

    assert_manual_rb_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_stb && manual_span && cmd == OP_RD_ASPAN) |=>
            rb_data_o[SPAN_W-1:0] == $past(span_pins));
endmodule

// File: tb/dbuf_regbank_bench.sv
`timescale 1ns/1ps
module dbuf_regbank_bench;
    localparam int NCH = 2;
    localparam int CW  = 16;
    localparam int SW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          hdr_stb = 1'b0;
    logic          frame_stb = 1'b0;
    logic [3:0]    cmd = 4'hF;
    logic [3:0]    addr = 4'h0;
    logic [CW-1:0] wdata = '0;
    logic          upd_n = 1'b1;
    logic          manual_span = 1'b0;
    logic [SW-1:0] span_pins = '0;
    logic [NCH*CW-1:0] act_code_o;
    logic [NCH*SW-1:0] act_span_o;
    logic [CW-1:0]     rb_data_o;

    always #2 clk = ~clk;

    dbuf_regbank #(.NCH(NCH), .CODE_W(CW), .SPAN_W(SW)) u_dbuf_regbank (
        .clk, .rst_n, .cs_n, .hdr_stb, .frame_stb, .cmd, .addr, .wdata,
        .upd_n, .manual_span, .span_pins, .act_code_o, .act_span_o, .rb_data_o
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    logic [CW-1:0] m_icode [NCH];
    logic [SW-1:0] m_ispan [NCH];
    logic [CW-1:0] m_acode [NCH];
    logic [SW-1:0] m_aspan [NCH];
    int            m_pch;
    int            m_pbuf;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] m_view(int ch, int b);
        case (b)
            0: return m_icode[ch];
            1: return CW'(manual_span ? span_pins : m_ispan[ch]);
            2: return m_acode[ch];
            default: return CW'(manual_span ? span_pins : m_aspan[ch]);
        endcase
    endfunction

    function automatic bit is_read(logic [3:0] c);
        return (c >= 4'h5) && (c <= 4'h8);
    endfunction

    function automatic int sel_ch(logic [3:0] a);
        return (int'(a) < NCH) ? int'(a) : 0;
    endfunction

    task automatic m_copy_all();
        for (int c = 0; c < NCH; c++) begin
            m_acode[c] = m_icode[c];
            m_aspan[c] = m_ispan[c];
        end
    endtask

    task automatic m_apply(logic [3:0] c, logic [3:0] a, logic [CW-1:0] d, bit ldac);
        for (int ch = 0; ch < NCH; ch++) begin
            bit h;
            h = (int'(a) == ch) || (a == 4'hF);
            if (h && (c == 4'h0 || c == 4'h3)) m_icode[ch] = d;
            if (h && c == 4'h1)                m_ispan[ch] = d[SW-1:0];
            if ((h && (c == 4'h2 || c == 4'h3)) || c == 4'h4) begin
                m_acode[ch] = m_icode[ch];
                m_aspan[ch] = m_ispan[ch];
            end
        end
        if (ldac) m_copy_all();
        case (c)
            4'h0: begin m_pch = sel_ch(a); m_pbuf = 0; end
            4'h1: begin m_pch = sel_ch(a); m_pbuf = 1; end
            4'h2, 4'h3: begin m_pch = sel_ch(a); m_pbuf = 2; end
            4'h4: begin m_pch = 0; m_pbuf = 2; end
            4'h5, 4'h6, 4'h7, 4'h8: begin m_pch = sel_ch(a); m_pbuf = int'(c) - 5; end
            default: ;
        endcase
    endtask

    task automatic chk_outputs(input string tag);
        for (int c = 0; c < NCH; c++) begin
            chk(tag, 32'(act_code_o[c*CW +: CW]), 32'(m_acode[c]));
            chk(tag, 32'(act_span_o[c*SW +: SW]), 32'(manual_span ? span_pins : m_aspan[c]));
        end
    endtask

    // one frame; ldac holds the update pin low across the frame (R12)
    task automatic run_frame(logic [3:0] c, logic [3:0] a, logic [CW-1:0] d, bit ldac);
        logic [CW-1:0] exp_rb;
        @(negedge clk);
        cs_n = 1'b0; cmd = c; addr = a; wdata = d;
        if (ldac) upd_n = 1'b0;
        repeat (2) @(negedge clk);
        hdr_stb = 1'b1;
        if (is_read(c)) exp_rb = m_view(sel_ch(a), int'(c) - 5);
        else            exp_rb = m_view(m_pch, m_pbuf);
        @(negedge clk);
        hdr_stb = 1'b0;
        if (is_read(c)) chk((c == 4'h6 || c == 4'h8) ? "R5 R8 span read" : "R5 read", 32'(rb_data_o), 32'(exp_rb));
        else            chk("R6 rolling readback", 32'(rb_data_o), 32'(exp_rb));
        @(negedge clk);
        cs_n = 1'b1; frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        m_apply(c, a, d, ldac);
        chk_outputs(ldac ? "R12 command then update" : "R2 R3 R4 R7 R11 outputs");
        if (ldac) begin
            upd_n = 1'b1;
            repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd2718);
        for (int c = 0; c < NCH; c++) begin
            m_icode[c] = '0; m_ispan[c] = '0; m_acode[c] = '0; m_aspan[c] = '0;
        end
        m_pch = 0; m_pbuf = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 reset code", 32'(act_code_o), 32'd0);
        chk("R1 reset span", 32'(act_span_o), 32'd0);
        chk("R1 reset readback", 32'(rb_data_o), 32'd0);
        run_frame(4'hF, 4'h0, 16'h1234, 0);        // R1: pointer at ch0 input code -> 0

        // R2 writes, R6 rolling
        run_frame(4'h0, 4'h0, 16'hA5A5, 0);
        run_frame(4'h1, 4'h1, 16'hFFF5, 0);        // span 5 into ch1
        run_frame(4'hF, 4'h0, 16'h0000, 0);        // R6 returns ch1 input span = 5
        run_frame(4'h0, 4'h7, 16'hDEAD, 0);        // R2 invalid address writes nothing
        run_frame(4'h0, 4'hF, 16'h0F0F, 0);        // broadcast write
        // R3 update one, write+update
        run_frame(4'h2, 4'h1, 16'h0000, 0);
        run_frame(4'h3, 4'h0, 16'h7777, 0);
        // R4 update all
        run_frame(4'h1, 4'h0, 16'h0003, 0);
        run_frame(4'h4, 4'h9, 16'h0000, 0);
        // R5 R8 reads
        run_frame(4'h8, 4'h0, 16'h0000, 0);
        run_frame(4'h5, 4'hF, 16'h0000, 0);
        run_frame(4'h7, 4'h1, 16'h0000, 0);
        // R7 unused code
        run_frame(4'hB, 4'h1, 16'hBEEF, 0);
        run_frame(4'hF, 4'h1, 16'hBEEF, 0);

        // R9 async update while idle
        run_frame(4'h0, 4'h1, 16'h4242, 0);
        @(negedge clk); upd_n = 1'b0;
        repeat (5) @(negedge clk);
        upd_n = 1'b1;
        m_copy_all();
        repeat (4) @(negedge clk);
        chk_outputs("R9 async update");

        // R10 lockout during a frame
        run_frame(4'h0, 4'h0, 16'h9999, 0);
        @(negedge clk); cs_n = 1'b0; cmd = 4'hF;
        upd_n = 1'b0;
        repeat (5) @(negedge clk);
        upd_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_outputs("R10 lockout");

        // R11 manual span
        manual_span = 1'b1; span_pins = 3'b110;
        @(negedge clk);
        chk_outputs("R11 manual outputs");
        run_frame(4'h6, 4'h1, 16'h0000, 0);
        run_frame(4'h1, 4'h0, 16'h0001, 0);
        run_frame(4'hF, 4'h0, 16'h0000, 0);
        manual_span = 1'b0;
        @(negedge clk);
        chk_outputs("R11 manual released");

        // R12 directed overlap
        run_frame(4'h0, 4'h1, 16'hC0DE, 1);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [3:0] rc, ra;
            int k;
            k = int'($urandom % 14);
            if (k < 9)       rc = 4'(k);
            else if (k < 12) rc = 4'hF;
            else             rc = 4'(9 + ($urandom % 6));
            k = int'($urandom % 8);
            if (k < 3)       ra = 4'h0;
            else if (k < 6)  ra = 4'h1;
            else if (k < 7)  ra = 4'hF;
            else             ra = 4'($urandom);
            manual_span = (($urandom % 5) == 0);
            span_pins   = SW'($urandom);
            run_frame(rc, ra, CW'($urandom), (($urandom % 8) == 0));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule